// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital timing controller behind a bit-serial, pipelined analog-to-digital converter. It runs on the peripheral clock. A power-of-two divider produces the converter clock as one-clock enables at each half-period boundary, so no second clock domain exists. A software start bit or an event input asks for a conversion. The request launches a conversion at the next converter-cycle boundary, provided it was registered at least one peripheral clock before that boundary.

Each conversion emits an optional gain-stage strobe, a sample strobe and one strobe per result bit, most significant first, with one bit every half converter period. The analog side answers each bit strobe on a per-bit decision bus. The sequencer collects the answers into a 12-bit result register, in which an 8-bit result is right-aligned. A sticky ready flag is raised once the result is written. Conversions overlap in a pool of lanes, so a new one can launch on every converter cycle.

Top module: `adc_seq_top`

## Requirements
- R1: One converter cycle lasts `4 << psc` peripheral clocks (psc 0..7 gives 4..512), split into two halves of equal length. The divider counter restarts from zero when reset is released.
- R2: A start (`start_sw` or `start_evt` high for a clock) launches a conversion at the first converter-cycle boundary that is at least one peripheral clock after the clock edge that sampled it. A request sampled on the last clock of a cycle slips a whole cycle.
- R3: With `gain_en`=0, `samp_stb` pulses in the first half of the launch cycle. With `gain_en`=1, `gain_stb` pulses in that half and `samp_stb` moves one converter cycle later. Each strobe lasts one peripheral clock at the start of its half.
- R4: `bit_stb[b]` marks bit b. Bits are strobed MSB first, one per half period, starting in the half right after the sample strobe: 8 bits with `res12`=0, 12 bits with `res12`=1.
- R5: `conv_done` pulses in the last half of a conversion. The conversion spans 2*(1 + RES/2 + G) halves, where RES is 8 or 12 and G is 1 with gain and 0 without.
- R6: The result register takes the `cmp_dec[b]` value present at each `bit_stb[b]`. In 8-bit mode bits 11..8 read as zero.
- R7: `result` and `irq_flag` update together on the clock after `conv_done`. The flag is never set before that.
- R8: `irq_flag` stays high until `flag_clr`=1 or `res_rd`=1. A done in the same clock as a clear leaves the flag set, and `res_rd` does not alter `result`.
- R9: If a start is pending at every boundary, a conversion launches every converter cycle and one completes every converter cycle.
- R10: During and right after reset, all strobes, `result` and `irq_flag` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| psc | input | 3 | Converter clock divider select, cycle = 4 << psc clocks |
| res12 | input | 1 | 1 = 12-bit result, 0 = 8-bit result |
| gain_en | input | 1 | Insert the gain-stage cycle before sampling |
| start_sw | input | 1 | Software start request |
| start_evt | input | 1 | Event start request |
| cmp_dec | input | 12 | Comparator decision for each bit position |
| flag_clr | input | 1 | Write-one clear of the ready flag |
| res_rd | input | 1 | Result read, clears the ready flag |
| samp_stb | output | 1 | Converter sample strobe |
| gain_stb | output | 1 | Gain-stage sample strobe |
| bit_stb | output | 12 | Per-bit resolve strobes |
| conv_done | output | 1 | Final-half strobe of a conversion |
| result | output | 12 | Result register |
| irq_flag | output | 1 | Result-ready flag |

## Verification
On every cycle, the assertions check several properties. Each half period is at least two clocks long. Strobes open only on a half boundary. A launch always finds its lane idle or in its final half. The flag follows a done and falls after a clear with no competing set. An 8-bit result never carries upper bits. The exact cycle of every strobe relative to the start, the slip when a request comes late, the assembled result values and the back-to-back throughput are shown only by the bench's scenarios. The bench computes those from the start phase and the divider setting.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int RES_MAX  = 12;
  localparam int RES_LOW  = 8;
  localparam int LANE_CNT = 8;
  localparam int HALF_W   = 5;

  // number of bits resolved for the selected resolution
  function automatic logic [HALF_W-1:0] res_bits(input logic r12);
    return r12 ? HALF_W'(RES_MAX) : HALF_W'(RES_LOW);
  endfunction

  // half-periods before the sample strobe (gain stage occupies one cycle)
  function automatic logic [HALF_W-1:0] samp_half(input logic g);
    return g ? HALF_W'(2) : HALF_W'(0);
  endfunction

  // total halves of one conversion: 2*(1 + RES/2 + G)
  function automatic logic [HALF_W-1:0] conv_halves(input logic r12, input logic g);
    return HALF_W'(2) + res_bits(r12) + samp_half(g);
  endfunction
endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PSC_W-1:0] psc,
  output logic             cyc_last,
  output logic             half_last,
  output logic             half_first
);
  localparam int CNT_W = 2 + (1 << PSC_W) - 1;
  localparam int LEN_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_full;
  logic [CNT_W-1:0] len_m1;
  logic [CNT_W-1:0] half_m1;

  always_comb begin
    len_full = LEN_W'(4) << psc;
    len_m1   = CNT_W'(len_full - LEN_W'(1));
    half_m1  = CNT_W'((len_full >> 1) - LEN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (cnt_q >= len_m1) cnt_q <= '0;
    else                      cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cyc_last   = (cnt_q >= len_m1);
  assign half_last  = cyc_last || (cnt_q == half_m1);
  assign half_first = (cnt_q == '0) || (cnt_q == half_m1 + CNT_W'(1));

  // R1: every half is at least two clocks, ending edge is followed by a start
  p_half_min_len_r1: assert property (@(posedge clk) disable iff (rst)
    half_last |=> (half_first && !half_last));
endmodule

// File: rtl/adc_seq_lane.sv
module adc_seq_lane
  import adc_seq_pkg::*;
#(
  parameter int RES_W = RES_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch_i,
  input  logic             r12_i,
  input  logic             gain_i,
  input  logic             half_adv_i,
  input  logic             half_first_i,
  input  logic [RES_W-1:0] cmp_dec_i,
  output logic             samp_o,
  output logic             gstb_o,
  output logic [RES_W-1:0] bstb_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             fin_o,
  output logic             r12_o,
  output logic [RES_W-1:0] acc_o
);
  logic              busy_q;
  logic [HALF_W-1:0] h_q;
  logic              r12_q;
  logic              g_q;
  logic [RES_W-1:0]  acc_q;

  logic [HALF_W-1:0] last_h;
  logic [HALF_W-1:0] off;
  logic [HALF_W-1:0] top_h;
  logic [HALF_W-1:0] bidx;
  logic              in_bits;
  logic              act_first;

  always_comb begin
    last_h    = conv_halves(r12_q, g_q) - HALF_W'(1);
    off       = samp_half(g_q);
    top_h     = off + res_bits(r12_q);
    in_bits   = (h_q > off) && (h_q <= top_h);
    bidx      = top_h - h_q;
    act_first = busy_q && half_first_i;
  end

  assign samp_o = act_first && (h_q == off);
  assign gstb_o = act_first && g_q && (h_q == '0);
  assign done_o = act_first && (h_q == last_h);
  assign fin_o  = busy_q && (h_q == last_h);
  assign busy_o = busy_q;
  assign r12_o  = r12_q;
  assign acc_o  = acc_q;

  for (genvar i = 0; i < RES_W; i++) begin : g_bit
    assign bstb_o[i] = act_first && in_bits && (bidx == HALF_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      h_q    <= '0;
      r12_q  <= 1'b0;
      g_q    <= 1'b0;
      acc_q  <= '0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      h_q    <= '0;
      r12_q  <= r12_i;
      g_q    <= gain_i;
      acc_q  <= '0;
    end else begin
      if (busy_q && half_adv_i) begin
        if (h_q == last_h) busy_q <= 1'b0;
        else               h_q    <= h_q + HALF_W'(1);
      end
      for (int i = 0; i < RES_W; i++) begin
        if (bstb_o[i]) acc_q[i] <= cmp_dec_i[i];
      end
    end
  end

  // R3: sample and gain strobes only open right after a half boundary
  p_strobe_on_half_r3: assert property (@(posedge clk) disable iff (rst)
    (samp_o || gstb_o) |-> $past(half_adv_i));
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_i,
  input  logic [RES_W-1:0] acc_i,
  input  logic             r12_i,
  input  logic             clr_i,
  input  logic             rd_i,
  output logic [RES_W-1:0] result_o,
  output logic             flag_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      flag_o   <= 1'b0;
    end else begin
      if (done_i) result_o <= acc_i;
      flag_o <= done_i || (flag_o && !(clr_i || rd_i));
    end
  end

  // R7: a finished conversion always leaves the flag set
  p_flag_after_done_r7: assert property (@(posedge clk) disable iff (rst)
    done_i |=> flag_o);
  // R8: a clear with no competing set drops the flag
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_o && (clr_i || rd_i) && !done_i) |=> !flag_o);
  // R6: an 8-bit result carries no upper bits
  p_res8_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (done_i && !r12_i) |=> (result_o[RES_W-1:8] == '0));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int RES_W = RES_MAX,
  parameter int LANES = LANE_CNT,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PSC_W-1:0] psc,
  input  logic             res12,
  input  logic             gain_en,
  input  logic             start_sw,
  input  logic             start_evt,
  input  logic [RES_W-1:0] cmp_dec,
  input  logic             flag_clr,
  input  logic             res_rd,
  output logic             samp_stb,
  output logic             gain_stb,
  output logic [RES_W-1:0] bit_stb,
  output logic             conv_done,
  output logic [RES_W-1:0] result,
  output logic             irq_flag
);
  localparam int PTR_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic cyc_last, half_last, half_first;
  logic pend_q, launch;
  logic [PTR_W-1:0] ptr_q;

  logic [LANES-1:0] l_launch, l_samp, l_gstb, l_done, l_busy, l_fin, l_r12;
  logic [RES_W-1:0] l_bstb [LANES];
  logic [RES_W-1:0] l_acc  [LANES];

  logic [RES_W-1:0] done_acc;
  logic             done_r12;

  adc_seq_clkdiv #(.PSC_W(PSC_W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .psc        (psc),
    .cyc_last   (cyc_last),
    .half_last  (half_last),
    .half_first (half_first)
  );

  // pending request: must be registered before the boundary edge
  assign launch = cyc_last && pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      pend_q <= start_sw || start_evt || (pend_q && !launch);
      if (launch) ptr_q <= (ptr_q == PTR_W'(LANES - 1)) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign l_launch[i] = launch && (ptr_q == PTR_W'(i));
    adc_seq_lane #(.RES_W(RES_W)) u_lane (
      .clk          (clk),
      .rst          (rst),
      .launch_i     (l_launch[i]),
      .r12_i        (res12),
      .gain_i       (gain_en),
      .half_adv_i   (half_last),
      .half_first_i (half_first),
      .cmp_dec_i    (cmp_dec),
      .samp_o       (l_samp[i]),
      .gstb_o       (l_gstb[i]),
      .bstb_o       (l_bstb[i]),
      .done_o       (l_done[i]),
      .busy_o       (l_busy[i]),
      .fin_o        (l_fin[i]),
      .r12_o        (l_r12[i]),
      .acc_o        (l_acc[i])
    );
  end

  always_comb begin
    bit_stb  = '0;
    done_acc = '0;
    done_r12 = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      bit_stb = bit_stb | l_bstb[i];
      if (l_done[i]) begin
        done_acc = l_acc[i];
        done_r12 = l_r12[i];
      end
    end
  end

  assign samp_stb  = |l_samp;
  assign gain_stb  = |l_gstb;
  assign conv_done = |l_done;

  adc_seq_result #(.RES_W(RES_W)) u_res (
    .clk      (clk),
    .rst      (rst),
    .done_i   (conv_done),
    .acc_i    (done_acc),
    .r12_i    (done_r12),
    .clr_i    (flag_clr),
    .rd_i     (res_rd),
    .result_o (result),
    .flag_o   (irq_flag)
  );

  // R9: a launch never lands on a lane still mid-conversion
  p_lane_free_r9: assert property (@(posedge clk) disable iff (rst)
    launch |-> (!l_busy[ptr_q] || l_fin[ptr_q]));
  // R2: a conversion only starts at a converter-cycle boundary
  p_launch_on_boundary_r2: assert property (@(posedge clk) disable iff (rst)
    launch |=> (half_first && |l_busy));
endmodule

// File: tb/adc_seq_top_tb_top.sv
module adc_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  psc = '0;
  logic        res12 = 1'b0, gain_en = 1'b0;
  logic        start_sw = 1'b0, start_evt = 1'b0;
  logic [11:0] cmp_dec = '0;
  logic        flag_clr = 1'b0, res_rd = 1'b0;
  logic        samp_stb, gain_stb, conv_done, irq_flag;
  logic [11:0] bit_stb, result;

  adc_seq_top dut_i (
    .clk(clk), .rst(rst), .psc(psc), .res12(res12), .gain_en(gain_en),
    .start_sw(start_sw), .start_evt(start_evt), .cmp_dec(cmp_dec),
    .flag_clr(flag_clr), .res_rd(res_rd), .samp_stb(samp_stb),
    .gain_stb(gain_stb), .bit_stb(bit_stb), .conv_done(conv_done),
    .result(result), .irq_flag(irq_flag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int E = 0, wd = 0;
  int samp_E, gain_E, msb_E, done_E, bitcnt, dones, last_done, gap_min, gap_max;
  int msb_idx;
  logic flag_at_done, flag_post, post_pend;
  logic [11:0] res_post;
  bit finished = 0;

  always @(posedge clk) begin
    if (rst) E <= 0; else E <= E + 1;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd >= WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", wd, WD_LIMIT);
      summary();
    end
  end

  always @(negedge clk) begin
    if (post_pend) begin
      flag_post = irq_flag;
      res_post  = result;
      post_pend = 0;
    end
    if (samp_stb && samp_E < 0) samp_E = E;
    if (gain_stb && gain_E < 0) gain_E = E;
    if (bit_stb[msb_idx] && msb_E < 0) msb_E = E;
    bitcnt += $countones(bit_stb);
    if (conv_done) begin
      dones++;
      if (last_done >= 0) begin
        if (E - last_done < gap_min) gap_min = E - last_done;
        if (E - last_done > gap_max) gap_max = E - last_done;
      end
      last_done = E;
      if (done_E < 0) begin
        done_E = E;
        flag_at_done = irq_flag;
      end
      post_pend = 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int f_div(int p);      return 4 << p; endfunction
  function automatic int f_bits(bit r);     return r ? 12 : 8; endfunction
  function automatic int f_halves(bit r, bit g); return 2 * (1 + f_bits(r) / 2 + (g ? 1 : 0)); endfunction
  function automatic int f_wait(int ph, int dv); return (ph == dv - 1) ? dv : dv - 1 - ph; endfunction
  function automatic int f_mask(bit r);     return r ? 12'hFFF : 12'h0FF; endfunction

  task automatic clear_mon(bit r);
    samp_E = -1; gain_E = -1; msb_E = -1; done_E = -1; bitcnt = 0; dones = 0;
    last_done = -1; gap_min = 1 << 30; gap_max = 0; post_pend = 0;
    flag_at_done = 1'bx; flag_post = 1'bx; res_post = 'x;
    msb_idx = f_bits(r) - 1;
  endtask

  task automatic do_reset(int p, bit r, bit g);
    @(negedge clk);
    rst = 1; psc = 3'(p); res12 = r; gain_en = g;
    start_sw = 0; start_evt = 0; flag_clr = 0; res_rd = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    clear_mon(r);
  endtask

  task automatic run_one(int p, bit r, bit g, logic [11:0] pat, int ph, bit src, bit clr_hold);
    int dv, hh, tt, es, el;
    dv = f_div(p); hh = dv / 2; tt = f_halves(r, g);
    do_reset(p, r, g);
    cmp_dec = pat; flag_clr = clr_hold;
    while ((E % dv) != ph) @(negedge clk);
    es = E;
    if (src) start_evt = 1; else start_sw = 1;
    @(negedge clk);
    start_evt = 0; start_sw = 0;
    el = es + 1 + f_wait(ph, dv);
    while (E < el + tt * hh + 3) @(negedge clk);
    chk("R3 sample strobe time", samp_E, el + (g ? 2 : 0) * hh);
    chk("R3 gain strobe time", gain_E, g ? el : -1);
    chk("R4 MSB strobe time", msb_E, el + ((g ? 2 : 0) + 1) * hh);
    chk("R4 bit strobe count", bitcnt, f_bits(r));
    chk("R2 R5 R1 done strobe time", done_E, el + (tt - 1) * hh);
    chk("R7 flag low at done", int'(flag_at_done), 0);
    chk("R7 flag set after done", int'(flag_post), 1);
    chk("R6 assembled result", int'(res_post), int'(pat) & f_mask(r));
    if (clr_hold) chk("R8 clear wins after set", int'(irq_flag), 0);
    flag_clr = 0;
  endtask

  initial begin
    int p, ph, dummy;
    bit r, g, s;
    logic [11:0] pat;
    dummy = $urandom(32'd2024);

    // R10 reset state
    repeat (2) @(negedge clk);
    chk("R10 strobes in reset", int'({samp_stb, gain_stb, conv_done, bit_stb}), 0);
    chk("R10 result in reset", int'(result), 0);
    chk("R10 flag in reset", int'(irq_flag), 0);
    do_reset(0, 0, 0);
    @(negedge clk);
    chk("R10 state after reset", int'({irq_flag, result, conv_done, samp_stb}), 0);

    // directed: slip vs just-in-time request (R2)
    run_one(0, 0, 0, 12'hA5C, 3, 0, 0);
    run_one(0, 1, 0, 12'h3C9, 2, 1, 0);
    run_one(2, 1, 1, 12'hF0F, 15, 0, 0);
    run_one(1, 0, 1, 12'h0B6, 6, 1, 0);
    run_one(7, 1, 1, 12'h5A5, 100, 0, 0);

    // R8 write-one clear
    run_one(0, 1, 0, 12'h777, 0, 0, 0);
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
    chk("R8 flag after clear", int'(irq_flag), 0);
    // R8 read clears, result unchanged
    run_one(1, 0, 0, 12'h1E3, 1, 1, 0);
    @(negedge clk); res_rd = 1; @(negedge clk); res_rd = 0;
    chk("R8 flag after read", int'(irq_flag), 0);
    chk("R8 result kept after read", int'(result), 12'h0E3);
    // R8 set wins over simultaneous clear
    run_one(0, 0, 1, 12'hCAF, 1, 0, 1);

    // random mix
    for (int n = 0; n < 8; n++) begin
      p = $urandom_range(0, 3);
      r = 1'($urandom_range(0, 1));
      g = 1'($urandom_range(0, 1));
      s = 1'($urandom_range(0, 1));
      pat = 12'($urandom);
      ph = $urandom_range(0, f_div(p) - 1);
      run_one(p, r, g, pat, ph, s, 0);
    end

    // R9 back-to-back conversions
    begin
      int dv, hold;
      dv = f_div(1); hold = 8 * dv;
      do_reset(1, 1, 1);
      cmp_dec = 12'h96D;
      while ((E % dv) != 0) @(negedge clk);
      start_evt = 1;
      repeat (hold) @(negedge clk);
      start_evt = 0;
      repeat (f_halves(1, 1) * dv + 4 * dv) @(negedge clk);
      chk("R9 conversions completed", dones, hold / dv + 1);
      chk("R9 min done spacing", gap_min, dv);
      chk("R9 max done spacing", gap_max, dv);
      chk("R9 last result", int'(result), 12'h96D);
    end

    summary();
  end
endmodule